// File: doc/BRIEF.md
# UART Register Front End

This block sits between a simple word-wide bus and the functional parts of a UART. Each access arrives on a one-cycle access strobe that carries a write enable, a 12-bit byte address and a 32-bit write word. The block decodes the address into one of the UART's software-visible registers and stores the configuration fields: baud divisors, line setup, control, FIFO trigger levels, interrupt mask and DMA enables. It returns read data one cycle after the access.

The block does not hold the receive FIFO, the serial shifter or the interrupt logic. Those parts feed it flag, receive-data and raw-interrupt inputs. It drives single-cycle strobes back to them: a receive pop, a transmit push with its byte, a FIFO reset and an interrupt clear with its bit mask. It also holds a break level.

The top 32 bytes of the 4 KB window hold eight read-only identification bytes. A parameter picks one of two identification sets.

Top module: `uart_regfront`

## Requirements
- R1: After reset the rdValid output is 0 and the strobe outputs are 0. The FIFO-level field (iflsOut) reads 0x12. The integer divisor, fractional divisor, line setup, control, interrupt mask and DMA fields are all 0, and breakOut is 0.
- R2: A read accepted at a clock edge shows its data on rdata, with rdValid high for exactly one cycle, after that edge. The integer divisor at byte offset 0x024 keeps only wdata[15:0]. The fractional divisor at 0x028 keeps only wdata[5:0]. The control register at 0x030 keeps 16 bits. The FIFO level at 0x034 keeps 6 bits. The DMA control at 0x048 keeps 3 bits. Each reads back its stored value, zero-extended.
- R3: Word reads at byte offsets 0xFE0 to 0xFFC return one identification byte each, indexed by (offset − 0xFE0) >> 2. With ID_VARIANT=0 the bytes are 0x11,0x10,0x14,0x00,0x0D,0xF0,0x05,0xB1. With ID_VARIANT=1 they are 0x11,0x00,0x18,0x01,0x0D,0xF0,0x05,0xB1.
- R4: A read of the flag register at 0x018 returns flagsIn (9 bits). A write to 0x018 changes no stored field and raises no strobe.
- R5: A write to the interrupt clear register at 0x044 raises intClear for one cycle, with intClearBits equal to wdata[10:0]. A read of 0x044 returns 0.
- R6: The 11-bit interrupt mask at 0x038 reads back its stored value. The raw status at 0x03C reads intRaw. The masked status at 0x040 reads intRaw AND mask.
- R7: A write to the data register at 0x000 raises txPush for one cycle, with txData equal to wdata[7:0]. A read of 0x000 raises rxPop for one cycle and returns rxData (12 bits). The same read loads rxData[11:8] into the receive status register at 0x004.
- R8: Any write to the receive status register at 0x004 clears all four of its error bits to 0.
- R9: The line setup register at 0x02C keeps 8 bits. Bit 4 is the FIFO enable and bit 0 is the send-break bit. A write that changes bit 4 raises fifoReset for one cycle, and a write that leaves bit 4 as it was does not. breakOut follows the stored bit 0.
- R10: A read at an undecoded word, or at an address with addr[1:0] not zero, returns 0. A write there changes no stored field and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| acc | input | 1 | Access strobe, one cycle per access |
| wrEn | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address within the window |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Read word, valid with rdValid |
| rdValid | output | 1 | Read data valid pulse |
| flagsIn | input | 9 | Live flag bits from the UART core |
| rxData | input | 12 | Head receive entry: error nibble and byte |
| rxPop | output | 1 | Receive pop strobe |
| txPush | output | 1 | Transmit push strobe |
| txData | output | 8 | Byte pushed for transmit |
| intRaw | input | 11 | Raw interrupt status from interrupt logic |
| intClear | output | 1 | Interrupt clear strobe |
| intClearBits | output | 11 | Bits to clear with intClear |
| ibrdOut | output | 16 | Integer baud divisor |
| fbrdOut | output | 6 | Fractional baud divisor |
| lcrOut | output | 8 | Line setup field |
| crOut | output | 16 | Control field |
| iflsOut | output | 6 | FIFO trigger level select |
| imscOut | output | 11 | Interrupt mask |
| dmacrOut | output | 3 | DMA enables |
| fifoReset | output | 1 | Receive FIFO reset strobe |
| breakOut | output | 1 | Send-break level |

## Verification
One line setup write can both change the FIFO enable and set the send-break bit. In that case fifoReset and the rising breakOut must appear in the same cycle. The bench writes 0x61 over a stored 0x70. It then checks that fifoReset and breakOut are both high at the sample point after that write, and that the stored value reads back as 0x61. It also checks the case where neither function occurs: a write that leaves the enable bit unchanged must not pulse fifoReset.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DR, SEL_RSR, SEL_FR, SEL_IBRD, SEL_FBRD, SEL_LCR, SEL_CR,
    SEL_IFLS, SEL_IMSC, SEL_RIS, SEL_MIS, SEL_ICR, SEL_DMACR, SEL_ID
  } regSelT;

  typedef struct packed {
    logic       rd;
    logic       wr;
    regSelT     sel;
    logic [2:0] idIdx;
  } strobeT;

  function automatic logic [7:0] idByte(input int variant, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h11;
      3'd1: b = (variant == 0) ? 8'h10 : 8'h00;
      3'd2: b = (variant == 0) ? 8'h14 : 8'h18;
      3'd3: b = (variant == 0) ? 8'h00 : 8'h01;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/uart_regfront_ctrl.sv
module uart_regfront_ctrl
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              acc,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            strb
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-4:0] ID_PAGE = '1;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;
  regSelT            selDec;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    selDec = SEL_NONE;
    if (wordIdx[WORD_W-1:3] == ID_PAGE) begin
      selDec = SEL_ID;
    end else begin
      case (wordIdx)
        WORD_W'(0):  selDec = SEL_DR;
        WORD_W'(1):  selDec = SEL_RSR;
        WORD_W'(6):  selDec = SEL_FR;
        WORD_W'(9):  selDec = SEL_IBRD;
        WORD_W'(10): selDec = SEL_FBRD;
        WORD_W'(11): selDec = SEL_LCR;
        WORD_W'(12): selDec = SEL_CR;
        WORD_W'(13): selDec = SEL_IFLS;
        WORD_W'(14): selDec = SEL_IMSC;
        WORD_W'(15): selDec = SEL_RIS;
        WORD_W'(16): selDec = SEL_MIS;
        WORD_W'(17): selDec = SEL_ICR;
        WORD_W'(18): selDec = SEL_DMACR;
        default:     selDec = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb.rd    = acc & ~wrEn;
    strb.wr    = acc & wrEn;
    strb.sel   = aligned ? selDec : SEL_NONE;
    strb.idIdx = wordIdx[2:0];
  end

endmodule

// File: rtl/uart_regfront_dp.sv
module uart_regfront_dp
  import uart_regfront_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IBRD_W     = 16,
  parameter int FBRD_W     = 6,
  parameter int LCR_W      = 8,
  parameter int CR_W       = 16,
  parameter int IFLS_W     = 6,
  parameter int IMSC_W     = 11,
  parameter int DMA_W      = 3,
  parameter int FLAG_W     = 9,
  parameter int RXD_W      = 12,
  parameter int FEN_BIT    = 4,
  parameter int BRK_BIT    = 0,
  parameter int ID_VARIANT = 0,
  parameter logic [IFLS_W-1:0] IFLS_RESET = 6'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [RXD_W-1:0]  rxData,
  input  logic [IMSC_W-1:0] intRaw,
  output logic [DATA_W-1:0] rdata,
  output logic              rdValid,
  output logic              rxPop,
  output logic              txPush,
  output logic [7:0]        txData,
  output logic              intClear,
  output logic [IMSC_W-1:0] intClearBits,
  output logic [IBRD_W-1:0] ibrdOut,
  output logic [FBRD_W-1:0] fbrdOut,
  output logic [LCR_W-1:0]  lcrOut,
  output logic [CR_W-1:0]   crOut,
  output logic [IFLS_W-1:0] iflsOut,
  output logic [IMSC_W-1:0] imscOut,
  output logic [DMA_W-1:0]  dmacrOut,
  output logic              fifoReset,
  output logic              breakOut
);
  localparam int ERR_W = RXD_W - 8;

  logic [IBRD_W-1:0] ibrdReg;
  logic [FBRD_W-1:0] fbrdReg;
  logic [LCR_W-1:0]  lcrReg;
  logic [CR_W-1:0]   crReg;
  logic [IFLS_W-1:0] iflsReg;
  logic [IMSC_W-1:0] imscReg;
  logic [DMA_W-1:0]  dmaReg;
  logic [ERR_W-1:0]  rsrReg;
  logic [DATA_W-1:0] rdNext;

  function automatic logic wrTo(input strobeT s, input regSelT r);
    return s.wr && (s.sel == r);
  endfunction

  always_comb begin
    rdNext = '0;
    case (strb.sel)
      SEL_DR:    rdNext = DATA_W'(rxData);
      SEL_RSR:   rdNext = DATA_W'(rsrReg);
      SEL_FR:    rdNext = DATA_W'(flagsIn);
      SEL_IBRD:  rdNext = DATA_W'(ibrdReg);
      SEL_FBRD:  rdNext = DATA_W'(fbrdReg);
      SEL_LCR:   rdNext = DATA_W'(lcrReg);
      SEL_CR:    rdNext = DATA_W'(crReg);
      SEL_IFLS:  rdNext = DATA_W'(iflsReg);
      SEL_IMSC:  rdNext = DATA_W'(imscReg);
      SEL_RIS:   rdNext = DATA_W'(intRaw);
      SEL_MIS:   rdNext = DATA_W'(intRaw & imscReg);
      SEL_DMACR: rdNext = DATA_W'(dmaReg);
      SEL_ID:    rdNext = DATA_W'(idByte(ID_VARIANT, strb.idIdx));
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibrdReg <= '0; fbrdReg <= '0; lcrReg <= '0; crReg <= '0;
      iflsReg <= IFLS_RESET; imscReg <= '0; dmaReg <= '0; rsrReg <= '0;
      rdata <= '0; rdValid <= 1'b0; rxPop <= 1'b0; txPush <= 1'b0;
      txData <= '0; intClear <= 1'b0; intClearBits <= '0; fifoReset <= 1'b0;
    end else begin
      rdValid   <= strb.rd;
      rdata     <= strb.rd ? rdNext : '0;
      rxPop     <= strb.rd && (strb.sel == SEL_DR);
      txPush    <= wrTo(strb, SEL_DR);
      intClear  <= wrTo(strb, SEL_ICR);
      fifoReset <= wrTo(strb, SEL_LCR) && (wdata[FEN_BIT] != lcrReg[FEN_BIT]);
      if (wrTo(strb, SEL_DR))    txData  <= wdata[7:0];
      if (wrTo(strb, SEL_ICR))   intClearBits <= wdata[IMSC_W-1:0];
      if (wrTo(strb, SEL_IBRD))  ibrdReg <= wdata[IBRD_W-1:0];
      if (wrTo(strb, SEL_FBRD))  fbrdReg <= wdata[FBRD_W-1:0];
      if (wrTo(strb, SEL_LCR))   lcrReg  <= wdata[LCR_W-1:0];
      if (wrTo(strb, SEL_CR))    crReg   <= wdata[CR_W-1:0];
      if (wrTo(strb, SEL_IFLS))  iflsReg <= wdata[IFLS_W-1:0];
      if (wrTo(strb, SEL_IMSC))  imscReg <= wdata[IMSC_W-1:0];
      if (wrTo(strb, SEL_DMACR)) dmaReg  <= wdata[DMA_W-1:0];
      if (wrTo(strb, SEL_RSR))
        rsrReg <= '0;
      else if (strb.rd && (strb.sel == SEL_DR))
        rsrReg <= rxData[RXD_W-1:8];
    end
  end

  assign ibrdOut  = ibrdReg;
  assign fbrdOut  = fbrdReg;
  assign lcrOut   = lcrReg;
  assign crOut    = crReg;
  assign iflsOut  = iflsReg;
  assign imscOut  = imscReg;
  assign dmacrOut = dmaReg;
  assign breakOut = lcrReg[BRK_BIT];

  assert_ibrd_only_by_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ibrdReg != $past(ibrdReg)) |-> $past(strb.wr && strb.sel == SEL_IBRD));

  assert_fr_write_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.sel == SEL_FR) |=>
      ($stable(lcrReg) && $stable(crReg) && $stable(ibrdReg) && $stable(imscReg)
       && !txPush && !intClear && !fifoReset));

  assert_icr_reads_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.sel == SEL_ICR) |=> (rdValid && rdata == '0));

  assert_fifo_reset_on_toggle_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoReset |-> (lcrReg[FEN_BIT] != $past(lcrReg[FEN_BIT])));

  assert_undecoded_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.sel == SEL_NONE) |=> (rdValid && rdata == '0));

  assert_rsr_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.sel == SEL_RSR) |=> (rsrReg == '0));

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int IBRD_W     = 16,
  parameter int FBRD_W     = 6,
  parameter int LCR_W      = 8,
  parameter int CR_W       = 16,
  parameter int IFLS_W     = 6,
  parameter int IMSC_W     = 11,
  parameter int DMA_W      = 3,
  parameter int FLAG_W     = 9,
  parameter int RXD_W      = 12,
  parameter int ID_VARIANT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              acc,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdValid,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [RXD_W-1:0]  rxData,
  output logic              rxPop,
  output logic              txPush,
  output logic [7:0]        txData,
  input  logic [IMSC_W-1:0] intRaw,
  output logic              intClear,
  output logic [IMSC_W-1:0] intClearBits,
  output logic [IBRD_W-1:0] ibrdOut,
  output logic [FBRD_W-1:0] fbrdOut,
  output logic [LCR_W-1:0]  lcrOut,
  output logic [CR_W-1:0]   crOut,
  output logic [IFLS_W-1:0] iflsOut,
  output logic [IMSC_W-1:0] imscOut,
  output logic [DMA_W-1:0]  dmacrOut,
  output logic              fifoReset,
  output logic              breakOut
);
  strobeT strb;

  uart_regfront_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .acc(acc), .wrEn(wrEn), .addr(addr), .strb(strb)
  );

  uart_regfront_dp #(
    .DATA_W(DATA_W), .IBRD_W(IBRD_W), .FBRD_W(FBRD_W), .LCR_W(LCR_W),
    .CR_W(CR_W), .IFLS_W(IFLS_W), .IMSC_W(IMSC_W), .DMA_W(DMA_W),
    .FLAG_W(FLAG_W), .RXD_W(RXD_W), .ID_VARIANT(ID_VARIANT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(wdata), .flagsIn(flagsIn),
    .rxData(rxData), .intRaw(intRaw), .rdata(rdata), .rdValid(rdValid),
    .rxPop(rxPop), .txPush(txPush), .txData(txData), .intClear(intClear),
    .intClearBits(intClearBits), .ibrdOut(ibrdOut), .fbrdOut(fbrdOut),
    .lcrOut(lcrOut), .crOut(crOut), .iflsOut(iflsOut), .imscOut(imscOut),
    .dmacrOut(dmacrOut), .fifoReset(fifoReset), .breakOut(breakOut)
  );

endmodule

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        acc = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [8:0]  flagsIn = '0;
  logic [11:0] rxData = '0;
  logic [10:0] intRaw = '0;
  logic [31:0] rdata, rdataB;
  logic        rdValid, rdValidB;
  logic        rxPop, txPush, intClear, fifoReset, breakOut;
  logic [7:0]  txData;
  logic [10:0] intClearBits, imscOut;
  logic [15:0] ibrdOut, crOut;
  logic [5:0]  fbrdOut, iflsOut;
  logic [7:0]  lcrOut;
  logic [2:0]  dmacrOut;
  logic        rxPopB, txPushB, intClearB, fifoResetB, breakOutB;
  logic [7:0]  txDataB, lcrOutB;
  logic [10:0] intClearBitsB, imscOutB;
  logic [15:0] ibrdOutB, crOutB;
  logic [5:0]  fbrdOutB, iflsOutB;
  logic [2:0]  dmacrOutB;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  uart_regfront dut (
    .clk(clk), .rstN(rstN), .acc(acc), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdValid(rdValid), .flagsIn(flagsIn), .rxData(rxData),
    .rxPop(rxPop), .txPush(txPush), .txData(txData), .intRaw(intRaw),
    .intClear(intClear), .intClearBits(intClearBits), .ibrdOut(ibrdOut),
    .fbrdOut(fbrdOut), .lcrOut(lcrOut), .crOut(crOut), .iflsOut(iflsOut),
    .imscOut(imscOut), .dmacrOut(dmacrOut), .fifoReset(fifoReset), .breakOut(breakOut)
  );

  uart_regfront #(.ID_VARIANT(1)) dutB (
    .clk(clk), .rstN(rstN), .acc(acc), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdataB), .rdValid(rdValidB), .flagsIn(flagsIn), .rxData(rxData),
    .rxPop(rxPopB), .txPush(txPushB), .txData(txDataB), .intRaw(intRaw),
    .intClear(intClearB), .intClearBits(intClearBitsB), .ibrdOut(ibrdOutB),
    .fbrdOut(fbrdOutB), .lcrOut(lcrOutB), .crOut(crOutB), .iflsOut(iflsOutB),
    .imscOut(imscOutB), .dmacrOut(dmacrOutB), .fifoReset(fifoResetB), .breakOut(breakOutB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read word when the design presents one
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected read data", 32'h1, 32'h0);
      end else begin
        check(tagQ.pop_front(), rdata, expQ.pop_front());
      end
    end
  end

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    acc = 1'b1; wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    acc = 1'b0; wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    acc = 1'b1; wrEn = 1'b0; addr = a;
    @(negedge clk);
    acc = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] idA [8];
    logic [7:0] idB [8];
    idA = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    idB = '{8'h11, 8'h00, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdValid", 32'(rdValid), 0);
    check("R1 iflsOut", 32'(iflsOut), 32'h12);
    check("R1 ibrdOut", 32'(ibrdOut), 0);
    check("R1 fbrdOut", 32'(fbrdOut), 0);
    check("R1 lcrOut/crOut", {lcrOut, crOut}, 0);
    check("R1 imsc/dma", {imscOut, dmacrOut}, 0);
    check("R1 strobes", {rxPop, txPush, intClear, fifoReset, breakOut}, 0);
    doRead(12'h034, 32'h12, "R1 ifls read");

    // R2 masking and read-back
    doWrite(12'h024, 32'hFFFF_FFFF);
    doRead(12'h024, 32'h0000_FFFF, "R2 ibrd mask");
    doWrite(12'h028, 32'hFFFF_FFFF);
    doRead(12'h028, 32'h3F, "R2 fbrd mask");
    doWrite(12'h030, 32'hABCD_EF12);
    doRead(12'h030, 32'hEF12, "R2 cr");
    doWrite(12'h034, 32'hFF);
    doRead(12'h034, 32'h3F, "R2 ifls");
    doWrite(12'h048, 32'hFF);
    doRead(12'h048, 32'h7, "R2 dmacr");
    check("R2 ibrdOut", 32'(ibrdOut), 32'hFFFF);

    // R3 identification bytes, both variants
    for (int i = 0; i < 8; i++) begin
      doRead(12'hFE0 + 12'(i * 4), 32'(idA[i]), $sformatf("R3 id variant0 byte %0d", i));
      check($sformatf("R3 id variant1 byte %0d", i), rdataB, 32'(idB[i]));
    end

    // R4 flag register
    flagsIn = 9'h1A5;
    doRead(12'h018, 32'h1A5, "R4 flag read");
    doWrite(12'h018, 32'hFFFF_FFFF);
    check("R4 flag write strobes", {txPush, intClear, fifoReset}, 0);
    check("R4 flag write fields", {lcrOut, crOut, ibrdOut}, {8'h00, 16'hEF12, 16'hFFFF});
    check("R4 flag write mask/fbrd", {imscOut, fbrdOut, iflsOut}, {11'h0, 6'h3F, 6'h3F});

    // R6 mask, raw, masked
    doWrite(12'h038, 32'hFFFF);
    doRead(12'h038, 32'h7FF, "R6 imsc mask");
    intRaw = 11'h0A5;
    doRead(12'h03C, 32'h0A5, "R6 raw status");
    doWrite(12'h038, 32'h00F);
    doRead(12'h040, 32'h005, "R6 masked status");

    // R5 interrupt clear
    doWrite(12'h044, 32'hF830);
    check("R5 intClear pulse", 32'(intClear), 1);
    check("R5 intClearBits", 32'(intClearBits), 32'h030);
    @(negedge clk);
    check("R5 intClear one cycle", 32'(intClear), 0);
    doRead(12'h044, 32'h0, "R5 clear reads zero");

    // R7 data register
    doWrite(12'h000, 32'h0012_34AB);
    check("R7 txPush", 32'(txPush), 1);
    check("R7 txData", 32'(txData), 32'hAB);
    rxData = 12'hA5C;
    doRead(12'h000, 32'hA5C, "R7 rx data");
    check("R7 rxPop", 32'(rxPop), 1);
    rxData = 12'h000;
    doRead(12'h004, 32'hA, "R7 rsr capture");

    // R8 status clear
    doWrite(12'h004, 32'h0);
    doRead(12'h004, 32'h0, "R8 rsr cleared");

    // R9 line setup: toggle, no toggle, toggle with break in the same write
    doWrite(12'h02C, 32'h10);
    check("R9 fifoReset on enable", 32'(fifoReset), 1);
    check("R9 no break", 32'(breakOut), 0);
    doWrite(12'h02C, 32'h70);
    check("R9 no fifoReset without toggle", 32'(fifoReset), 0);
    doWrite(12'h02C, 32'h61);
    check("R9 fifoReset and break same cycle", {31'(fifoReset), breakOut}, 32'h3);
    doRead(12'h02C, 32'h61, "R9 lcr read");

    // R10 undecoded and unaligned
    doRead(12'h0FC, 32'h0, "R10 undecoded read");
    doRead(12'h026, 32'h0, "R10 unaligned read");
    doWrite(12'h025, 32'h1234);
    check("R10 unaligned write ignored", 32'(ibrdOut), 32'hFFFF);
    doWrite(12'h0FC, 32'hFFFF_FFFF);
    check("R10 undecoded write strobes", {txPush, intClear, fifoReset}, 0);
    doRead(12'h024, 32'hFFFF, "R10 ibrd unchanged");
    doRead(12'h02C, 32'h61, "R10 lcr unchanged");

    repeat (3) @(negedge clk);
    check("R2 all reads answered", expQ.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule